// File: doc/BRIEF.md
# Time-Shared FIR / LMS Filter Engine

This block computes finite impulse response filters with a single multiplier-accumulator that steps through a sample history and a coefficient store, one tap per clock. A sample presented with its strobe while the engine is idle is taken in. The engine reports busy until the result is ready, and any sample offered while it is busy is dropped. The operating mode is chosen per sample. It can run one long filter, two independent half-length filters, or an adaptive filter that corrects its own coefficients by the least-mean-squares rule.

The coefficient store holds two complete sets. A select input chooses which set a sample uses. In adaptive mode the engine makes two passes over the taps for each sample. The first pass forms the output. The error against the desired input is formed between the passes, and the second pass rewrites every active coefficient of the chosen set. The step size is a power-of-two right shift. A host can load coefficients through a simple write port, but only while the engine is idle.

Top module: `fir_lms_engine`

## Requirements
- R1: After reset, busy, out_valid, y_a, y_b and err are 0, and every history entry and coefficient of both sets is 0, so a first sample gives y_a = 0.
- R2: Mode codes 0 and 3 select a single filter of N taps. The result is y_a = sat16(floor(sum over k<N of c[s][k]*x_a[n-k] / 2^14)), where x_a[n] is the sample just taken and s is the set select. out_valid pulses for one cycle, exactly N clock edges after the accepting edge.
- R3: Mode code 1 selects two filters. Channel A uses the in_a history with coefficient addresses 0..N-1. Channel B uses the in_b history with addresses 128..128+N-1. Each result follows the R2 formula. Both results appear with a single out_valid pulse 2N edges after acceptance.
- R4: Mode code 2 (adaptive) gives y_a from the in_a history as in R2, and err = sat16(desired - y_a). Both are reported with out_valid 2N edges after acceptance.
- R5: In adaptive mode, every coefficient k<N of the selected set becomes sat16(c[k] + floor(err*x_a[n-k] / 2^(14+mu_shift))) after the sample, and the next sample uses the new values.
- R6: set_sel (0 or 1) at acceptance chooses coefficient set s. The other set is neither used nor changed.
- R7: busy is 1 from the edge after acceptance until the edge that raises out_valid. A sample offered while busy is ignored: the history does not move and no extra result appears.
- R8: A host write (cw_en, cw_set, cw_addr, cw_data) takes effect at the next edge only if busy is 0. A write made while busy is discarded.
- R9: The tap count N is the taps input, with 0 taken as 1 and values above the mode limit (256 for modes 0, 2 and 3; 128 for mode 1) taken as the limit.
- R10: In adaptive mode, with the desired signal taken from a fixed 4-tap system, the error after 300 samples stays within ±64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0/3 single, 1 dual, 2 adaptive; sampled at acceptance |
| taps | input | 9 | Requested tap count, clamped per R9 |
| set_sel | input | 1 | Coefficient set used by this sample |
| mu_shift | input | 4 | Extra right shift of the adaptive step |
| in_valid | input | 1 | Sample strobe |
| in_a | input | 16 | Sample for channel A (signed) |
| in_b | input | 16 | Sample for channel B in dual mode (signed) |
| desired | input | 16 | Desired signal for adaptive mode (signed) |
| cw_en | input | 1 | Host coefficient write strobe |
| cw_set | input | 1 | Set written by the host |
| cw_addr | input | 8 | Coefficient address |
| cw_data | input | 16 | Coefficient value (signed, 14 fraction bits) |
| busy | output | 1 | Engine is processing a sample |
| out_valid | output | 1 | One-cycle result strobe |
| y_a | output | 16 | Single, channel-A or adaptive output |
| y_b | output | 16 | Channel-B output in dual mode |
| err | output | 16 | Adaptive error |

## Verification
A sample taken at some edge gets its result after exactly N further edges in single mode, and after 2N in dual and adaptive modes. Between those points busy must read 1 and out_valid 0. The bench counts falling edges from the acceptance edge and compares busy and out_valid on every one of them. It compares the result values only on the falling edge where the pulse is due, and on the edge after that it checks that the pulse has ended. Samples and host writes offered while busy are placed on the first edge after acceptance, so their only possible effect shows up in later results, which the reference model predicts without them.

// File: rtl/fir_lms_pkg.sv
package fir_lms_pkg;
    typedef enum logic [1:0] {
        OP_SINGLE     = 2'd0,
        OP_DUAL       = 2'd1,
        OP_ADAPT      = 2'd2,
        OP_SINGLE_ALT = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CONV_A = 2'd1,
        PH_CONV_B = 2'd2,
        PH_UPDATE = 2'd3
    } phase_e;
endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic                 dual,
    input  logic signed [DW-1:0] din_a,
    input  logic signed [DW-1:0] din_b,
    input  logic        [AW-1:0] rd_idx,
    output logic signed [DW-1:0] rd_data,
    output logic        [AW-1:0] wr_ptr
);
    logic        [AW-1:0] ptr_q, ptr_d;
    logic signed [DW-1:0] line_q [DEPTH];

    always_comb begin
        ptr_d = push ? ptr_q + 1'b1 : ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            if (push) begin
                if (dual) begin
                    line_q[{1'b0, ptr_q[AW-2:0]}] <= din_a;
                    line_q[{1'b1, ptr_q[AW-2:0]}] <= din_b;
                end else begin
                    line_q[ptr_q] <= din_a;
                end
            end
        end
    end

    assign rd_data = line_q[rd_idx];
    assign wr_ptr  = ptr_q;

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(ptr_q)); // R7
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (ptr_q == $past(ptr_q) + AW'(1))); // R7
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
    parameter int CW    = 16,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic                 host_set,
    input  logic        [AW-1:0] host_addr,
    input  logic signed [CW-1:0] host_data,
    input  logic                 upd_we,
    input  logic                 upd_set,
    input  logic        [AW-1:0] upd_addr,
    input  logic signed [CW-1:0] upd_data,
    input  logic                 rd_set,
    input  logic        [AW-1:0] rd_addr,
    output logic signed [CW-1:0] rd_data
);
    localparam int ENTRIES = 2 * DEPTH;

    logic signed [CW-1:0] mem_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
        end else if (upd_we) begin
            mem_q[{upd_set, upd_addr}] <= upd_data;
        end else if (host_we) begin
            mem_q[{host_set, host_addr}] <= host_data;
        end
    end

    assign rd_data = mem_q[{rd_set, rd_addr}];

    AST_HOST_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> !upd_we); // R8
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int ACCW = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   en,
    input  logic signed [DW-1:0]   x,
    input  logic signed [CW-1:0]   c,
    output logic signed [ACCW-1:0] sum
);
    localparam int PW = DW + CW;

    typedef struct packed {
        logic signed [ACCW-1:0] acc;
    } mac_t;

    mac_t                 st_q, st_d;
    logic signed [PW-1:0] prod;

    always_comb begin
        prod = x * c;
        sum  = st_q.acc + {{(ACCW-PW){prod[PW-1]}}, prod};
        st_d = st_q;
        if (clr)     st_d.acc = '0;
        else if (en) st_d.acc = sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
    import fir_lms_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int ACCW  = 40,
    parameter int FRAC  = 14,
    parameter int MUW   = 4,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             mode_in,
    input  logic [AW:0]            taps_in,
    input  logic                   set_in,
    input  logic [MUW-1:0]         mu_in,
    input  logic signed [DW-1:0]   desired_in,
    input  logic [AW-1:0]          wr_ptr,
    input  logic signed [DW-1:0]   line_data,
    input  logic signed [CW-1:0]   coef_data,
    input  logic signed [ACCW-1:0] mac_sum,
    output logic                   accept,
    output logic                   push_dual,
    output logic [AW-1:0]          line_idx,
    output logic                   coef_set,
    output logic [AW-1:0]          coef_addr,
    output logic                   upd_we,
    output logic signed [CW-1:0]   upd_data,
    output logic                   mac_clr,
    output logic                   mac_en,
    output logic                   busy,
    output logic signed [DW-1:0]   y_a,
    output logic signed [DW-1:0]   y_b,
    output logic signed [DW-1:0]   err,
    output logic                   out_valid
);
    localparam int HALF = DEPTH / 2;
    localparam int UW   = 2 * DW + 1;

    typedef struct packed {
        phase_e                phase;
        op_mode_e              mode;
        logic [AW:0]           ntaps;
        logic [AW-1:0]         k;
        logic [AW-1:0]         head;
        logic                  cset;
        logic [MUW-1:0]        mu;
        logic signed [DW-1:0]  des;
        logic signed [DW-1:0]  ya;
        logic signed [DW-1:0]  yb;
        logic signed [DW-1:0]  err;
        logic                  vld;
    } ctrl_t;

    ctrl_t st_q, st_d;

    function automatic logic signed [DW-1:0] sat_dw(input logic signed [ACCW-1:0] v);
        logic signed [ACCW-1:0] hi;
        logic signed [ACCW-1:0] lo;
        hi = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
        lo = ~hi;
        if (v > hi)      return hi[DW-1:0];
        else if (v < lo) return lo[DW-1:0];
        else             return v[DW-1:0];
    endfunction

    function automatic logic signed [CW-1:0] sat_cw(input logic signed [UW-1:0] v);
        logic signed [UW-1:0] hi;
        logic signed [UW-1:0] lo;
        hi = {{(UW-CW+1){1'b0}}, {(CW-1){1'b1}}};
        lo = ~hi;
        if (v > hi)      return hi[CW-1:0];
        else if (v < lo) return lo[CW-1:0];
        else             return v[CW-1:0];
    endfunction

    op_mode_e               md;
    logic [AW:0]            lim;
    logic [AW:0]            ntaps_eff;
    logic                   last;
    logic [AW-1:0]          tap_off;
    logic signed [DW-1:0]   conv_y;
    logic signed [DW-1:0]   err_next;
    logic signed [2*DW-1:0] upd_prod;
    logic signed [2*DW-1:0] upd_step;
    logic                   dual_a;
    logic                   dual_b;

    always_comb begin
        case (mode_in)
            2'd1:    md = OP_DUAL;
            2'd2:    md = OP_ADAPT;
            default: md = OP_SINGLE;
        endcase
        lim = (md == OP_DUAL) ? (AW+1)'(HALF) : (AW+1)'(DEPTH);
        if (taps_in == '0)      ntaps_eff = (AW+1)'(1);
        else if (taps_in > lim) ntaps_eff = lim;
        else                    ntaps_eff = taps_in;

        accept    = in_valid && (st_q.phase == PH_IDLE);
        push_dual = (md == OP_DUAL);
        busy      = (st_q.phase != PH_IDLE);

        last    = ({1'b0, st_q.k} == (st_q.ntaps - 1'b1));
        tap_off = st_q.head - st_q.k;
        dual_a  = (st_q.phase == PH_CONV_A) && (st_q.mode == OP_DUAL);
        dual_b  = (st_q.phase == PH_CONV_B);

        if (dual_a) begin
            line_idx  = {1'b0, tap_off[AW-2:0]};
            coef_addr = {1'b0, st_q.k[AW-2:0]};
        end else if (dual_b) begin
            line_idx  = {1'b1, tap_off[AW-2:0]};
            coef_addr = {1'b1, st_q.k[AW-2:0]};
        end else begin
            line_idx  = tap_off;
            coef_addr = st_q.k;
        end
        coef_set = st_q.cset;

        mac_en  = (st_q.phase == PH_CONV_A) || (st_q.phase == PH_CONV_B);
        mac_clr = !(mac_en && !last);

        conv_y   = sat_dw(mac_sum >>> FRAC);
        err_next = sat_dw(ACCW'($signed(st_q.des)) - ACCW'(conv_y));

        upd_prod = $signed(st_q.err) * line_data;
        upd_step = upd_prod >>> (FRAC + int'(st_q.mu));
        upd_data = sat_cw(UW'(coef_data) + UW'(upd_step));
        upd_we   = (st_q.phase == PH_UPDATE);

        st_d     = st_q;
        st_d.vld = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.phase = PH_CONV_A;
                    st_d.mode  = md;
                    st_d.ntaps = ntaps_eff;
                    st_d.k     = '0;
                    st_d.head  = wr_ptr;
                    st_d.cset  = set_in;
                    st_d.mu    = mu_in;
                    st_d.des   = desired_in;
                end
            end
            PH_CONV_A: begin
                st_d.k = st_q.k + 1'b1;
                if (last) begin
                    st_d.k  = '0;
                    st_d.ya = conv_y;
                    case (st_q.mode)
                        OP_DUAL:  st_d.phase = PH_CONV_B;
                        OP_ADAPT: begin
                            st_d.err   = err_next;
                            st_d.phase = PH_UPDATE;
                        end
                        default: begin
                            st_d.phase = PH_IDLE;
                            st_d.vld   = 1'b1;
                        end
                    endcase
                end
            end
            PH_CONV_B: begin
                st_d.k = st_q.k + 1'b1;
                if (last) begin
                    st_d.k     = '0;
                    st_d.yb    = conv_y;
                    st_d.phase = PH_IDLE;
                    st_d.vld   = 1'b1;
                end
            end
            PH_UPDATE: begin
                st_d.k = st_q.k + 1'b1;
                if (last) begin
                    st_d.k     = '0;
                    st_d.phase = PH_IDLE;
                    st_d.vld   = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.mode  <= OP_SINGLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_a       = st_q.ya;
    assign y_b       = st_q.yb;
    assign err       = st_q.err;
    assign out_valid = st_q.vld;

    AST_K_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |-> ({1'b0, st_q.k} < st_q.ntaps)); // R9
    AST_DUAL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CONV_B) |-> ((st_q.ntaps <= (AW+1)'(HALF)) && (st_q.mode == OP_DUAL))); // R3
    AST_UPD_ADAPT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |-> (st_q.mode == OP_ADAPT)); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.phase == PH_IDLE)); // R7
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |=> $stable(st_q.head)); // R7
endmodule

// File: rtl/fir_lms_engine.sv
module fir_lms_engine #(
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int MAX_TAPS = 256,
    parameter int FRAC     = 14,
    parameter int MUW      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic [$clog2(MAX_TAPS):0] taps,
    input  logic                  set_sel,
    input  logic [MUW-1:0]        mu_shift,
    input  logic                  in_valid,
    input  logic signed [DW-1:0]  in_a,
    input  logic signed [DW-1:0]  in_b,
    input  logic signed [DW-1:0]  desired,
    input  logic                  cw_en,
    input  logic                  cw_set,
    input  logic [$clog2(MAX_TAPS)-1:0] cw_addr,
    input  logic signed [CW-1:0]  cw_data,
    output logic                  busy,
    output logic                  out_valid,
    output logic signed [DW-1:0]  y_a,
    output logic signed [DW-1:0]  y_b,
    output logic signed [DW-1:0]  err
);
    localparam int AW   = $clog2(MAX_TAPS);
    localparam int ACCW = DW + CW + AW;

    logic                   accept;
    logic                   push_dual;
    logic [AW-1:0]          wr_ptr;
    logic [AW-1:0]          line_idx;
    logic signed [DW-1:0]   line_data;
    logic                   coef_set;
    logic [AW-1:0]          coef_addr;
    logic signed [CW-1:0]   coef_data;
    logic                   upd_we;
    logic signed [CW-1:0]   upd_data;
    logic                   mac_clr;
    logic                   mac_en;
    logic signed [ACCW-1:0] mac_sum;
    logic                   host_we;

    assign host_we = cw_en && !busy;

    fir_delay_line #(.DW(DW), .DEPTH(MAX_TAPS), .AW(AW)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (accept),
        .dual    (push_dual),
        .din_a   (in_a),
        .din_b   (in_b),
        .rd_idx  (line_idx),
        .rd_data (line_data),
        .wr_ptr  (wr_ptr)
    );

    fir_coef_store #(.CW(CW), .DEPTH(MAX_TAPS), .AW(AW)) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_set  (cw_set),
        .host_addr (cw_addr),
        .host_data (cw_data),
        .upd_we    (upd_we),
        .upd_set   (coef_set),
        .upd_addr  (coef_addr),
        .upd_data  (upd_data),
        .rd_set    (coef_set),
        .rd_addr   (coef_addr),
        .rd_data   (coef_data)
    );

    fir_mac #(.DW(DW), .CW(CW), .ACCW(ACCW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mac_clr),
        .en    (mac_en),
        .x     (line_data),
        .c     (coef_data),
        .sum   (mac_sum)
    );

    fir_ctrl #(
        .DW(DW), .CW(CW), .ACCW(ACCW), .FRAC(FRAC), .MUW(MUW),
        .DEPTH(MAX_TAPS), .AW(AW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .mode_in    (mode),
        .taps_in    (taps),
        .set_in     (set_sel),
        .mu_in      (mu_shift),
        .desired_in (desired),
        .wr_ptr     (wr_ptr),
        .line_data  (line_data),
        .coef_data  (coef_data),
        .mac_sum    (mac_sum),
        .accept     (accept),
        .push_dual  (push_dual),
        .line_idx   (line_idx),
        .coef_set   (coef_set),
        .coef_addr  (coef_addr),
        .upd_we     (upd_we),
        .upd_data   (upd_data),
        .mac_clr    (mac_clr),
        .mac_en     (mac_en),
        .busy       (busy),
        .y_a        (y_a),
        .y_b        (y_b),
        .err        (err),
        .out_valid  (out_valid)
    );
endmodule

// File: tb/sim_fir_lms_engine.sv
`timescale 1ns/1ps
module sim_fir_lms_engine;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = '0;
    logic [8:0]        taps = '0;
    logic              set_sel = 1'b0;
    logic [3:0]        mu_shift = '0;
    logic              in_valid = 1'b0;
    logic [15:0]       in_a = '0;
    logic [15:0]       in_b = '0;
    logic [15:0]       desired = '0;
    logic              cw_en = 1'b0;
    logic              cw_set = 1'b0;
    logic [7:0]        cw_addr = '0;
    logic [15:0]       cw_data = '0;
    logic              busy;
    logic              out_valid;
    logic signed [15:0] y_a;
    logic signed [15:0] y_b;
    logic signed [15:0] err;

    always #4 clk = ~clk;

    fir_lms_engine u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .taps(taps), .set_sel(set_sel),
        .mu_shift(mu_shift), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .desired(desired), .cw_en(cw_en), .cw_set(cw_set), .cw_addr(cw_addr),
        .cw_data(cw_data), .busy(busy), .out_valid(out_valid), .y_a(y_a),
        .y_b(y_b), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    int cm [512];
    int ha [256];
    int hb [256];
    int unsigned seed = 32'h1234_5678;

    function automatic int sat(longint v, int bits);
        longint hi = (longint'(1) <<< (bits - 1)) - 1;
        longint lo = -(longint'(1) <<< (bits - 1));
        if (v > hi) return int'(hi);
        if (v < lo) return int'(lo);
        return int'(v);
    endfunction

    function automatic int rnd(int span);
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'((seed >> 8) % (2 * span + 1)) - span;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 512; i++) cm[i] = 0;
        for (int i = 0; i < 256; i++) begin ha[i] = 0; hb[i] = 0; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; cw_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_clear();
    endtask

    task automatic wr_coef(int st, int a, int v);
        cw_en = 1'b1; cw_set = st[0]; cw_addr = a[7:0]; cw_data = v[15:0];
        @(negedge clk);
        cw_en = 1'b0;
        cm[st * 256 + a] = v;
    endtask

    task automatic run(int md, int nt, int st, int mu, int xa, int xb, int d,
                       bit poke, string tag, output int ye, output int ee);
        int em, lim, n, lat, ya, yb, e;
        longint acc;
        em  = (md == 3) ? 0 : md;
        lim = (em == 1) ? 128 : 256;
        n   = (nt == 0) ? 1 : ((nt > lim) ? lim : nt);
        lat = (em == 0) ? n : 2 * n;
        for (int i = 255; i > 0; i--) ha[i] = ha[i-1];
        ha[0] = xa;
        if (em == 1) begin
            for (int i = 255; i > 0; i--) hb[i] = hb[i-1];
            hb[0] = xb;
        end
        acc = 0;
        for (int k = 0; k < n; k++) acc += longint'(cm[st*256 + k]) * ha[k];
        ya = sat(acc >>> 14, 16);
        yb = 0;
        if (em == 1) begin
            acc = 0;
            for (int k = 0; k < n; k++) acc += longint'(cm[st*256 + 128 + k]) * hb[k];
            yb = sat(acc >>> 14, 16);
        end
        e = sat(longint'(d) - ya, 16);
        mode = md[1:0]; taps = nt[8:0]; set_sel = st[0]; mu_shift = mu[3:0];
        in_a = xa[15:0]; in_b = xb[15:0]; desired = d[15:0]; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 busy after accept", {busy, out_valid}, 2'b10);
        if (poke) begin
            in_valid = 1'b1; in_a = 16'h3039; in_b = 16'h0F0F;
            cw_en = 1'b1; cw_set = st[0]; cw_addr = 8'd0; cw_data = 16'd777;
        end
        for (int j = 1; j <= lat; j++) begin
            @(negedge clk);
            in_valid = 1'b0; cw_en = 1'b0;
            if (j < lat) begin
                if ({busy, out_valid} != 2'b10) chk("R7 busy window", {busy, out_valid}, 2'b10);
            end else begin
                chk({tag, " valid at latency"}, {busy, out_valid}, 2'b01);
                chk({tag, " y_a"}, y_a, ya);
                if (em == 1) chk({tag, " y_b"}, y_b, yb);
                if (em == 2) chk({tag, " err"}, err, e);
            end
        end
        n_chk++;
        @(negedge clk);
        chk({tag, " pulse ends"}, out_valid, 0);
        if (em == 2) begin
            for (int k = 0; k < n; k++)
                cm[st*256 + k] = sat(longint'(cm[st*256 + k]) + ((longint'(e) * ha[k]) >>> (14 + mu)), 16);
        end
        ye = ya; ee = e;
    endtask

    initial begin
        int ye, ee, x, d, maxe;
        do_reset();
        chk("R1 busy", busy, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 y_a", y_a, 0);
        chk("R1 y_b", y_b, 0);
        chk("R1 err", err, 0);
        run(0, 3, 0, 0, 9000, 0, 0, 0, "R1", ye, ee);

        wr_coef(0, 0, 9000); wr_coef(0, 1, -5000); wr_coef(0, 2, 3000);
        wr_coef(0, 3, 2000); wr_coef(0, 4, -1000); wr_coef(0, 255, 4000);
        wr_coef(1, 0, -7000); wr_coef(1, 1, 6000); wr_coef(1, 2, 1500);
        for (int i = 0; i < 12; i++) run(0, 5, 0, 0, rnd(16000), 0, 0, (i % 3) == 0, "R2", ye, ee);
        for (int i = 0; i < 4; i++)  run(0, 3, 1, 0, rnd(16000), 0, 0, i == 1, "R6", ye, ee);
        run(0, 0, 0, 0, rnd(16000), 0, 0, 0, "R9 zero taps", ye, ee);
        run(0, 300, 0, 0, rnd(16000), 0, 0, 1, "R9 over limit", ye, ee);
        run(3, 4, 0, 0, rnd(16000), 0, 0, 0, "R2 code 3", ye, ee);
        wr_coef(0, 0, 32767); wr_coef(0, 1, 32767);
        run(0, 2, 0, 0, 30000, 0, 0, 0, "R2 sat", ye, ee);
        run(0, 2, 0, 0, 30000, 0, 0, 0, "R2 sat high", ye, ee);
        chk("R2 positive clip", ye, 32767);
        run(0, 2, 0, 0, -30000, 0, 0, 0, "R2 sat", ye, ee);
        run(0, 2, 0, 0, -30000, 0, 0, 0, "R2 sat low", ye, ee);
        chk("R2 negative clip", ye, -32768);

        do_reset();
        wr_coef(0, 0, 8000); wr_coef(0, 1, 4000); wr_coef(0, 2, -2000); wr_coef(0, 3, 1000);
        wr_coef(0, 128, -6000); wr_coef(0, 129, 3000); wr_coef(0, 130, 2500); wr_coef(0, 131, -500);
        wr_coef(1, 0, 16384); wr_coef(1, 128, -16384);
        for (int i = 0; i < 10; i++) run(1, 4, 0, 0, rnd(16000), rnd(16000), 0, (i % 4) == 1, "R3", ye, ee);
        for (int i = 0; i < 3; i++)  run(1, 1, 1, 0, rnd(16000), rnd(16000), 0, 0, "R6 dual", ye, ee);
        run(1, 200, 0, 0, rnd(16000), rnd(16000), 0, 1, "R9 dual limit", ye, ee);

        do_reset();
        wr_coef(1, 0, 5000);
        maxe = 0;
        for (int i = 0; i < 300; i++) begin
            x = rnd(8000);
            d = sat((longint'(8000) * x - longint'(4000) * ha[0] + longint'(2000) * ha[1]
                     + longint'(1000) * ha[2]) >>> 14, 16);
            run(2, 4, 0, 0, x, 0, d, (i % 50) == 7, (i < 3) ? "R5" : "R4", ye, ee);
            if (i >= 280 && (ee > maxe || -ee > maxe)) maxe = (ee < 0) ? -ee : ee;
        end
        chk("R10 residual within 64", (maxe <= 64) ? 1 : 0, 1);
        run(2, 4, 0, 3, rnd(8000), 0, 100, 0, "R5 mu3", ye, ee);
        run(0, 1, 1, 0, 1000, 0, 0, 0, "R6 untouched set", ye, ee);
        chk("R6 set1 coefficient", ye, 305);
        run(0, 4, 0, 0, rnd(8000), 0, 0, 0, "R5 adapted set", ye, ee);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule